// File: doc/BRIEF.md
# Nine-Port Direction and Drive Controller

This block sets the direction of every pin of nine 8-bit general-purpose ports and produces the value that each pin drives. Ports are numbered 1 to 9. Port n occupies bits `8*(n-1)+7 .. 8*(n-1)` of the 72-bit pin vectors. A 3-bit hardware select input picks the mode. A select value of zero gives soft mode, where four command registers written over the host bus decide direction. Any other value gives hard mode, where the select code itself fixes the direction of ports 1 to 7 and port 9.

Port 8 is always configured per pin from command register 0, in both modes. In soft mode, ports 2 and 5 can be split into two independently controlled nibbles, and every other port is switched as a whole byte. Each port has a data latch. Data written while the port is still an input is held and appears on the pins as soon as the port turns into an output. Until a port's latch is first written, it drives a mode-dependent reset level. In hard mode that level is all ones by default, or all zeros when a parameter selects the other variant.

The host-side address decoding is outside this block. It delivers one-cycle write strobes for each command register and each port latch, together with a shared write data byte.

Top module: `port_dir_ctl`

## Requirements
- R1: `hw_sel_i == 0` selects soft mode (direction from command registers). Any non-zero value selects hard mode (direction from the select code). The code is read as a binary number with `hw_sel_i[0]` as the LSB.
- R2: In every command register a 0 bit means output and a 1 bit means input. After reset all four registers read all ones, so in soft mode every `oe_o` bit is 0 and every `pin_o` bit is 0.
- R3: Command register 0 (`cr_we_i[0]`) bit b sets the direction of port 8 pin b, in both modes.
- R4: Command register 1 (`cr_we_i[1]`), soft mode: bit 0 controls port 2 pins 0-3, bit 3 controls port 2 pins 4-7, bit 1 controls port 3, and bit 4 controls port 1.
- R5: Command register 2 (`cr_we_i[2]`), soft mode: bit 0 controls port 5 pins 0-3, bit 3 controls port 5 pins 4-7, bit 1 controls port 6, and bit 4 controls port 4.
- R6: Command register 3 (`cr_we_i[3]`), soft mode: bit 1 controls port 9 and bit 4 controls port 7. Bits 2, 5, 6 and 7 of registers 1 and 2, and bits 0, 2, 3, 5, 6 and 7 of register 3, have no effect on any output.
- R7: In hard mode, port 1 is always an input and port 9 is always an output.
- R8: In hard mode with select code k (1..7), ports 2 through k are inputs and the remaining ports among 2..7 are outputs. Code 1 makes all six outputs, and code 7 makes all six inputs.
- R9: `port_we_i[n-1]` loads `wdata_i` into port n's latch at the clock edge. A value loaded while the port is an input is driven on `pin_o` as soon as the port becomes an output.
- R10: A port whose latch has not been written since reset drives all ones in hard mode (all zeros when `HARD_FILL_ONES = 0`) and all zeros in soft mode.
- R11: For every pin that is an input, `oe_o` is 0 and `pin_o` is 0.
- R12: A change of `hw_sel_i` reaches `oe_o` and `pin_o` without waiting for a clock edge. A command register write takes effect from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_sel_i | input | 3 | Mode and hard-mode direction code |
| cr_we_i | input | 4 | Write strobe per command register (bit i = register i) |
| port_we_i | input | 9 | Write strobe per port latch (bit n-1 = port n) |
| wdata_i | input | 8 | Shared write data |
| pin_o | output | 72 | Pin drive value, zero on input pins |
| oe_o | output | 72 | Pin output enable, 1 = drive |

## Verification
The assertions assume that the write strobes are single-cycle pulses synchronous to `clk_i`, and that `wdata_i` is valid in the cycle a strobe is high. They also assume that `hw_sel_i` is a settled, glitch-free level, because direction follows it combinationally. The stimulus drives every input only at the falling clock edge and raises at most one strobe per cycle. Command registers and port latches are written with random data, and `hw_sel_i` moves between zero and random non-zero codes in between writes. Resets are applied with both soft and hard codes present, so that the undriven-latch reset level is exercised in each mode.

// File: rtl/port_dir_pkg.sv
package port_dir_pkg;
  localparam int NUM_PORTS = 9;
  localparam int PORT_W    = 8;
  localparam int NUM_CR    = 4;
  localparam int SEL_W     = 3;

  // Only the command register bits that steer a direction are kept
  typedef struct packed {
    logic [PORT_W-1:0] p8_in;
    logic              p1_in;
    logic              p2_lo_in;
    logic              p2_hi_in;
    logic              p3_in;
    logic              p4_in;
    logic              p5_lo_in;
    logic              p5_hi_in;
    logic              p6_in;
    logic              p7_in;
    logic              p9_in;
  } dir_ctl_t;
endpackage

// File: rtl/dir_ctl_regs.sv
module dir_ctl_regs
  import port_dir_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CR-1:0] cr_we_i,
  input  logic [PORT_W-1:0] wdata_i,
  output dir_ctl_t          ctl_o
);
  dir_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '1;
    end else begin
      if (cr_we_i[0]) ctl_q.p8_in <= wdata_i;
      if (cr_we_i[1]) begin
        ctl_q.p2_lo_in <= wdata_i[0];
        ctl_q.p3_in    <= wdata_i[1];
        ctl_q.p2_hi_in <= wdata_i[3];
        ctl_q.p1_in    <= wdata_i[4];
      end
      if (cr_we_i[2]) begin
        ctl_q.p5_lo_in <= wdata_i[0];
        ctl_q.p6_in    <= wdata_i[1];
        ctl_q.p5_hi_in <= wdata_i[3];
        ctl_q.p4_in    <= wdata_i[4];
      end
      if (cr_we_i[3]) begin
        ctl_q.p9_in <= wdata_i[1];
        ctl_q.p7_in <= wdata_i[4];
      end
    end
  end

  assign ctl_o = ctl_q;

  assert_cr0_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_i[0] |=> ctl_q.p8_in == $past(wdata_i));
  assert_cr3_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_we_i[3] |=> $stable({ctl_q.p9_in, ctl_q.p7_in}));
  assert_cr1_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_we_i[1] |=> $stable({ctl_q.p1_in, ctl_q.p2_lo_in, ctl_q.p2_hi_in, ctl_q.p3_in}));
endmodule

// File: rtl/dir_decode.sv
module dir_decode
  import port_dir_pkg::*;
#(
  localparam int PIN_W     = NUM_PORTS * PORT_W,
  localparam int NUM_THERM = NUM_PORTS - 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] hw_sel_i,
  input  dir_ctl_t         ctl_i,
  output logic [PIN_W-1:0] in_mask_o
);
  localparam int HW = PORT_W / 2;

  logic             hard;
  logic [PIN_W-1:0] soft_in;
  logic [PIN_W-1:0] hard_in;

  assign hard = |hw_sel_i;

  assign soft_in = {
    {PORT_W{ctl_i.p9_in}},
    ctl_i.p8_in,
    {PORT_W{ctl_i.p7_in}},
    {PORT_W{ctl_i.p6_in}},
    {{HW{ctl_i.p5_hi_in}}, {HW{ctl_i.p5_lo_in}}},
    {PORT_W{ctl_i.p4_in}},
    {PORT_W{ctl_i.p3_in}},
    {{HW{ctl_i.p2_hi_in}}, {HW{ctl_i.p2_lo_in}}},
    {PORT_W{ctl_i.p1_in}}
  };

  // hard mode: first port input, last output, second to last from CR0
  assign hard_in[PORT_W-1:0]                          = '1;
  assign hard_in[(NUM_PORTS-2)*PORT_W +: PORT_W]      = ctl_i.p8_in;
  assign hard_in[(NUM_PORTS-1)*PORT_W +: PORT_W]      = '0;

  // thermometer: port index j (0-based) is input when its 1-based number <= code
  for (genvar j = 1; j <= NUM_THERM; j++) begin : g_therm
    assign hard_in[j*PORT_W +: PORT_W] =
      (hw_sel_i >= SEL_W'(j + 1)) ? {PORT_W{1'b1}} : {PORT_W{1'b0}};
  end

  assign in_mask_o = hard ? hard_in : soft_in;

  logic [NUM_THERM-1:0] therm_obs;
  for (genvar j = 0; j < NUM_THERM; j++) begin : g_obs
    assign therm_obs[j] = in_mask_o[(j+1)*PORT_W];
  end

  assert_therm_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard |-> ((therm_obs & (therm_obs + 1'b1)) == '0));
  assert_therm_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard |-> ($countones(therm_obs) == int'(hw_sel_i) - 1));
  assert_hard_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard |-> (in_mask_o[PORT_W-1:0] == '1 &&
              in_mask_o[(NUM_PORTS-1)*PORT_W +: PORT_W] == '0));
endmodule

// File: rtl/port_latch.sv
module port_latch
  import port_dir_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] fill_i,
  output logic [PORT_W-1:0] val_o
);
  logic [PORT_W-1:0] data_q;
  logic              written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      written_q <= 1'b0;
    end else if (we_i) begin
      data_q    <= wdata_i;
      written_q <= 1'b1;
    end
  end

  // reset level follows the live mode until the first write
  assign val_o = written_q ? data_q : fill_i;

  assert_latch_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> val_o == $past(wdata_i));
  assert_latch_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && written_q) |=> $stable(val_o));
endmodule

// File: rtl/port_dir_ctl.sv
module port_dir_ctl
  import port_dir_pkg::*;
#(
  parameter bit HARD_FILL_ONES = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SEL_W-1:0]            hw_sel_i,
  input  logic [NUM_CR-1:0]           cr_we_i,
  input  logic [NUM_PORTS-1:0]        port_we_i,
  input  logic [PORT_W-1:0]           wdata_i,
  output logic [NUM_PORTS*PORT_W-1:0] pin_o,
  output logic [NUM_PORTS*PORT_W-1:0] oe_o
);
  localparam int PIN_W = NUM_PORTS * PORT_W;
  localparam int P8_LO = (NUM_PORTS - 2) * PORT_W;

  dir_ctl_t          ctl;
  logic [PIN_W-1:0]  in_mask;
  logic [PIN_W-1:0]  val;
  logic [PORT_W-1:0] fill;

  dir_ctl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cr_we_i (cr_we_i),
    .wdata_i (wdata_i),
    .ctl_o   (ctl)
  );

  dir_decode u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_sel_i  (hw_sel_i),
    .ctl_i     (ctl),
    .in_mask_o (in_mask)
  );

  assign fill = (|hw_sel_i) ? {PORT_W{HARD_FILL_ONES}} : '0;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_latch u_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (port_we_i[p]),
      .wdata_i (wdata_i),
      .fill_i  (fill),
      .val_o   (val[p*PORT_W +: PORT_W])
    );
  end

  assign oe_o  = ~in_mask;
  assign pin_o = val & oe_o;

  assert_p8_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_i[0] |=> oe_o[P8_LO +: PORT_W] == ~$past(wdata_i));
  assert_p9_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_sel_i && port_we_i[NUM_PORTS-1]) |=>
      (|hw_sel_i) -> (pin_o[P8_LO+PORT_W +: PORT_W] == $past(wdata_i)));
endmodule

// File: tb/port_dir_ctl_tb.sv
`timescale 1ns/1ps
module port_dir_ctl_tb;
  localparam int NP = 9;
  localparam int W  = 8;
  localparam int PW = NP * W;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    hw_sel = '0;
  logic [3:0]    cr_we = '0;
  logic [NP-1:0] port_we = '0;
  logic [W-1:0]  wdata = '0;
  logic [PW-1:0] pin, oe;

  always #2.5 clk = ~clk;

  port_dir_ctl u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .hw_sel_i  (hw_sel),
    .cr_we_i   (cr_we),
    .port_we_i (port_we),
    .wdata_i   (wdata),
    .pin_o     (pin),
    .oe_o      (oe)
  );

  logic [W-1:0] m_cr  [4];
  logic [W-1:0] m_lat [NP];
  logic         m_wr  [NP];
  int tests = 0;
  int fails = 0;
  bit done  = 0;

  function automatic logic [PW-1:0] m_in();
    logic [PW-1:0] r;
    if (hw_sel == 0) begin
      r[7:0]   = {8{m_cr[1][4]}};
      r[15:8]  = {{4{m_cr[1][3]}}, {4{m_cr[1][0]}}};
      r[23:16] = {8{m_cr[1][1]}};
      r[31:24] = {8{m_cr[2][4]}};
      r[39:32] = {{4{m_cr[2][3]}}, {4{m_cr[2][0]}}};
      r[47:40] = {8{m_cr[2][1]}};
      r[55:48] = {8{m_cr[3][4]}};
      r[63:56] = m_cr[0];
      r[71:64] = {8{m_cr[3][1]}};
    end else begin
      r[7:0] = 8'hFF;
      for (int n = 2; n <= 7; n++) r[8*(n-1) +: 8] = (n <= int'(hw_sel)) ? 8'hFF : 8'h00;
      r[63:56] = m_cr[0];
      r[71:64] = 8'h00;
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] m_pin();
    logic [PW-1:0] r;
    logic [PW-1:0] inm = m_in();
    for (int p = 0; p < NP; p++)
      r[8*p +: 8] = m_wr[p] ? m_lat[p] : ((hw_sel != 0) ? 8'hFF : 8'h00);
    return r & ~inm;
  endfunction

  task automatic check(string tag);
    logic [PW-1:0] e_oe = ~m_in();
    logic [PW-1:0] e_pin = m_pin();
    tests++;
    if (oe !== e_oe) begin
      fails++;
      $display("FAIL %s oe actual=%h expected=%h", tag, oe, e_oe);
    end
    if (pin !== e_pin) begin
      fails++;
      $display("FAIL %s pin actual=%h expected=%h", tag, pin, e_pin);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_ni = 1'b0;
    hw_sel = s;
    for (int i = 0; i < 4; i++) m_cr[i] = 8'hFF;
    for (int p = 0; p < NP; p++) begin m_lat[p] = '0; m_wr[p] = 1'b0; end
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic cr_write(input int i, input logic [7:0] d);
    @(negedge clk);
    cr_we = 4'(1 << i);
    wdata = d;
    @(posedge clk);
    #1;
    cr_we = '0;
    m_cr[i] = d;
  endtask

  task automatic port_write(input int p, input logic [7:0] d);
    @(negedge clk);
    port_we = NP'(1 << p);
    wdata = d;
    @(posedge clk);
    #1;
    port_we = '0;
    m_lat[p] = d;
    m_wr[p] = 1'b1;
  endtask

  task automatic set_sel(input logic [2:0] s);
    @(negedge clk);
    hw_sel = s;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    do_reset(3'd0);
    check("R2 reset soft all input");
    check("R11 input pins quiet");

    cr_write(0, 8'h5A);
    check("R3 cr0 soft per bit");

    foreach (m_cr[i]) ;
    cr_write(1, 8'hFE); check("R4 cr1 bit0 port2 low");
    cr_write(1, 8'hF7); check("R4 cr1 bit3 port2 high");
    cr_write(1, 8'hFD); check("R4 cr1 bit1 port3");
    cr_write(1, 8'hEF); check("R4 cr1 bit4 port1");
    cr_write(2, 8'hFE); check("R5 cr2 bit0 port5 low");
    cr_write(2, 8'hF7); check("R5 cr2 bit3 port5 high");
    cr_write(2, 8'hED); check("R5 cr2 bits1,4 ports6,4");
    cr_write(3, 8'hFD); check("R6 cr3 bit1 port9");
    cr_write(3, 8'hEF); check("R6 cr3 bit4 port7");
    cr_write(1, 8'h1B); check("R6 cr1 unused bits ignored");
    cr_write(2, 8'h1B); check("R6 cr2 unused bits ignored");
    cr_write(3, 8'h12); check("R6 cr3 unused bits ignored");

    port_write(2, 8'hC3); check("R11 preload held on input");
    cr_write(1, 8'h19);   check("R9 preload driven on turn to output");

    cr_write(0, 8'h0F);
    for (int k = 1; k <= 7; k++) begin
      set_sel(3'(k));
      check("R8 R7 R1 R12 hard code");
    end
    port_write(8, 8'h96); check("R10 R7 port9 written in hard");
    set_sel(3'd0); check("R1 R12 back to soft");

    do_reset(3'd3);
    check("R10 hard reset fill");
    cr_write(0, 8'h00); check("R3 cr0 in hard mode");

    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 3) cr_write(int'($urandom_range(0, 3)), 8'($urandom));
      else if (op < 6) port_write(int'($urandom_range(0, NP - 1)), 8'($urandom));
      else if (op < 9) set_sel(($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 7)));
      else do_reset(3'($urandom_range(0, 7)));
      check("R12 random mix");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule